// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers twenty single-cycle event pulses from a two-port video capture parser. It holds each one in a sticky pending bit and merges the pending bits into one interrupt line for the system interrupt controller. Each port supplies ten kinds of event: disable-complete, ancillary protocol violation, active-video protocol violation, source-0 frame size mismatch, link connect, link disconnect, ancillary output overflow, luma output overflow, input FIFO overflow and video detect.

Software reaches three registers over a small register bus. Writes take effect on the clock edge. Reads are combinational from the address. The pending register is read-only. The block register uses 1 to keep a source off the interrupt line. The flush register keeps whatever software writes to it. While a flush bit is 1, its pending bit stays at 0 and new events of that kind are dropped. Software must write the bit back to 0 before events of that kind can be latched again.

The block has no state machine. It is built from per-bit pending flops, a register bank and a registered OR stage.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the pending register reads 0, the block register reads all ones (0xFFFFF), the flush register reads 0 and `irq_out` is 0.
- R2: A one-cycle pulse on `evt_pulse[i]` sets pending bit i at the next clock edge. The bit stays 1 after the pulse ends, until a flush clears it.
- R3: The pending register is at address 0 and is read-only. A bus write to address 0 leaves every pending bit unchanged.
- R4: Writing 1 to flush bit i (address 2) makes pending bit i read 0 from the second clock edge after the write.
- R5: While flush bit i holds 1, pulses on `evt_pulse[i]` are lost. Once software writes the bit back to 0, a later pulse latches again.
- R6: In a cycle where flush bit i is 1 and `evt_pulse[i]` pulses, pending bit i stays 0. Sources whose flush bit is 0 still latch in that same cycle.
- R7: A block bit of 1 keeps its source off `irq_out`, but the pending bit still latches and reads back as 1.
- R8: `irq_out` equals the OR over all bits of (pending AND NOT block), delayed by one clock edge.
- R9: The block register (address 1) and the flush register (address 2) read back the last value written to them. Address 3 reads 0, and a write to address 3 changes neither register.
- R10: Pending bit i belongs to event input i. From bit 19 down to bit 0 the order is: B disable-complete, A disable-complete, B ancillary violation, B video violation, A ancillary violation, A video violation, B size, A size, B disconnect, B connect, A disconnect, A connect, B ancillary overflow, B luma overflow, A ancillary overflow, A luma overflow, B input overflow, A input overflow, B video detect, A video detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 20 | One-cycle event pulses, one per source |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 pending, 1 block, 2 flush, 3 unused |
| bus_wdata | input | 20 | Write data |
| bus_rdata | output | 20 | Read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
A pending bit that is stuck or lost shows up in the pending register one edge after the event that should have set it. The same fault shows on `irq_out` one edge later, once the source is unblocked. A flush flop that loses its value lets a dropped event reappear in the pending readback within one edge. A bad block bit makes the interrupt line either miss or assert one edge after the pending bit changes. The bench sweeps every source bit through latching and unblocking so that every such fault is exposed.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    localparam int NUM_PORTS    = 2;
    localparam int SRC_PER_PORT = 10;
    localparam int NUM_SRC      = NUM_PORTS * SRC_PER_PORT;

    typedef enum logic [1:0] {
        SEL_PENDING = 2'd0,
        SEL_BLOCK   = 2'd1,
        SEL_FLUSH   = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    // source bit positions (decoded by the interrupt handler)
    localparam int SRC_A_VDET    = 0;
    localparam int SRC_B_VDET    = 1;
    localparam int SRC_A_IN_OVF  = 2;
    localparam int SRC_B_IN_OVF  = 3;
    localparam int SRC_A_LUM_OVF = 4;
    localparam int SRC_A_ANC_OVF = 5;
    localparam int SRC_B_LUM_OVF = 6;
    localparam int SRC_B_ANC_OVF = 7;
    localparam int SRC_A_LINK_UP = 8;
    localparam int SRC_A_LINK_DN = 9;
    localparam int SRC_B_LINK_UP = 10;
    localparam int SRC_B_LINK_DN = 11;
    localparam int SRC_A_SIZE    = 12;
    localparam int SRC_B_SIZE    = 13;
    localparam int SRC_A_VID_ERR = 14;
    localparam int SRC_A_ANC_ERR = 15;
    localparam int SRC_B_VID_ERR = 16;
    localparam int SRC_B_ANC_ERR = 17;
    localparam int SRC_A_OFF_DONE = 18;
    localparam int SRC_B_OFF_DONE = 19;
endpackage

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_stat_pkg::*;
#(
    parameter int W = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] block_q,
    output logic [W-1:0] flush_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // block register: reset to all ones so every source starts quiet
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            block_q <= '1;
        else if (wr_en && sel == SEL_BLOCK)
            block_q <= wdata;
    end

    // flush register: level-held, software must return it to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flush_q <= '0;
        else if (wr_en && sel == SEL_FLUSH)
            flush_q <= wdata;
    end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] flush,
    output logic [W-1:0] pending
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pending[g] <= 1'b0;
            else if (flush[g])
                pending[g] <= 1'b0;
            else if (evt[g])
                pending[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pending,
    input  logic [W-1:0] block,
    output logic         irq
);
    logic [W-1:0] live;
    assign live = pending & ~block;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |live;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int W = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_pulse,
    input  logic         bus_wr_en,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq_out
);
    logic [W-1:0] pending_vec;
    logic [W-1:0] block_vec;
    logic [W-1:0] flush_vec;

    irq_regbank #(.W(W)) i_regbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .block_q (block_vec),
        .flush_q (flush_vec)
    );

    irq_sticky #(.W(W)) i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_pulse),
        .flush   (flush_vec),
        .pending (pending_vec)
    );

    irq_merge #(.W(W)) i_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending_vec),
        .block   (block_vec),
        .irq     (irq_out)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_PENDING: bus_rdata = pending_vec;
            SEL_BLOCK:   bus_rdata = block_vec;
            SEL_FLUSH:   bus_rdata = flush_vec;
            SEL_NONE:    bus_rdata = '0;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_pulse,
    input logic [W-1:0] pending_vec,
    input logic [W-1:0] block_vec,
    input logic [W-1:0] flush_vec,
    input logic         irq_out
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pending_vec == '0 && flush_vec == '0 && (&block_vec) && !irq_out));

    p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_vec & ~$past(pending_vec) & ~$past(evt_pulse)) == '0));

    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pending_vec) & ~$past(flush_vec) & ~pending_vec) == '0));

    p_flush_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_vec & $past(flush_vec)) == '0));

    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == |($past(pending_vec) & ~$past(block_vec))));

    p_all_blocked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&block_vec) |=> !irq_out);
endmodule

bind irq_status_ctrl irq_status_chk #(.W(W)) i_irq_status_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse   (evt_pulse),
    .pending_vec (pending_vec),
    .block_vec   (block_vec),
    .flush_vec   (flush_vec),
    .irq_out     (irq_out)
);

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
    localparam int W = 20;
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_pulse = '0;
    logic         bus_wr_en = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctrl #(.W(W)) i_irq_status_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [W-1:0] exp);
        logic [W-1:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic irq_check(input string req, input logic exp);
        #0.5;
        check(req, {{(W-1){1'b0}}, irq_out}, {{(W-1){1'b0}}, exp});
    endtask

    // write lands on the next posedge; returns at the negedge after it
    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [W-1:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp_pend;
        logic [W-1:0] blk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_check("R1 pending", 2'd0, '0);
        rd_check("R1 block", 2'd1, ALL1);
        rd_check("R1 flush", 2'd2, '0);
        irq_check("R1 irq", 1'b0);

        // R2 / R10 / R7: latch every source in bit order while all blocked
        exp_pend = '0;
        for (int i = 0; i < W; i++) begin
            pulse(W'(1) << i);
            exp_pend |= W'(1) << i;
            @(negedge clk);
            rd_check("R2 R10 sticky bit position", 2'd0, exp_pend);
            irq_check("R7 blocked source quiet", 1'b0);
        end
        check("R10 B disable-complete is bit 19", exp_pend[19] ? bus_rdata[19] : 1'b0, 1'b1);

        // R3: pending register ignores writes
        wr(2'd0, '0);
        @(negedge clk);
        rd_check("R3 pending read-only", 2'd0, ALL1);

        // R8: unblock each source alone; irq follows one edge later
        for (int i = 0; i < W; i++) begin
            wr(2'd1, ~(W'(1) << i));
            irq_check("R8 irq delayed one edge", 1'b0);
            @(negedge clk);
            irq_check("R8 irq on unblocked source", 1'b1);
            wr(2'd1, ALL1);
            @(negedge clk);
            irq_check("R8 irq drops when reblocked", 1'b0);
        end

        // R4: flush selected bits
        wr(2'd2, 20'h00F0F);
        rd_check("R9 flush readback", 2'd2, 20'h00F0F);
        @(negedge clk);
        rd_check("R4 flush clears pending", 2'd0, 20'hFF0F0);

        // R5: events lost while flush held
        pulse(ALL1);
        pulse(20'h00F0F);
        @(negedge clk);
        rd_check("R5 events lost under flush", 2'd0, 20'hFF0F0);
        wr(2'd2, '0);
        @(negedge clk);
        rd_check("R5 no change on flush release", 2'd0, 20'hFF0F0);
        pulse(20'h00001);
        @(negedge clk);
        rd_check("R5 relatch after release", 2'd0, 20'hFF0F1);

        // R6: flush wins per bit, neighbour latches in same cycle
        wr(2'd2, 20'h00002);
        pulse(20'h00006);
        @(negedge clk);
        rd_check("R6 flush wins, neighbour latches", 2'd0, 20'hFF0F5);
        wr(2'd2, '0);

        // R9: block readback, unused address
        wr(2'd1, 20'h5A5A5);
        rd_check("R9 block readback", 2'd1, 20'h5A5A5);
        wr(2'd3, 20'h12345);
        rd_check("R9 addr3 reads zero", 2'd3, '0);
        rd_check("R9 addr3 write leaves block", 2'd1, 20'h5A5A5);
        rd_check("R9 addr3 write leaves flush", 2'd2, '0);

        // R7 / R8: blocked pending still reads, irq computed from mask
        wr(2'd2, ALL1);
        @(negedge clk);
        wr(2'd2, '0);
        exp_pend = '0;
        for (int i = 0; i < W; i += 3) begin
            blk = 20'h5A5A5;
            pulse(W'(1) << i);
            exp_pend |= W'(1) << i;
            @(negedge clk);
            rd_check("R7 blocked source still pending", 2'd0, exp_pend);
            irq_check("R8 irq from pending and mask", |(exp_pend & ~blk));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule